// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects interrupt requests from eight peripheral lines and forwards the most urgent eligible one to a processor as a single interrupt signal. A rising edge on a line latches a pending request. When the processor acknowledges, the winning request moves into the in-service set. The controller then returns an interrupt type number on its vector port. The type number joins a programmable base with the index of the winning line. Fixed priority applies, and line 0 is the most urgent.

While a request is in service, the controller holds back every other request of the same or lower urgency. This lasts until the service routine writes a non-specific end-of-interrupt command, which retires the most urgent in-service entry. For systems with more than eight sources, one controller acts as master and up to eight others act as slaves on its inputs, for 64 sources in total. The master broadcasts a 3-bit identifier of the slave whose request won. A slave answers an acknowledge only when that identifier matches its own.

Software uses a small register port with a one-cycle write strobe and a registered read path. Through it, software sets the type base, a per-line mask, the cascade word and the role, and reads back the pending and in-service sets.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, int_out, vec_valid and cas_sel_out are 0, and the type base, mask, cascade word, role, pending set and in-service set all read back as 0.
- R2: A 0-to-1 transition on irq_in[i] sets pending bit i. A line held high does not set the bit again after its request has been acknowledged. Pending bits clear only on acknowledge.
- R3: Priority is fixed, with index 0 the most urgent. An acknowledge takes the lowest-index request that is pending and unmasked.
- R4: When mask bit i is 1, request i stays pending but cannot raise int_out or be acknowledged. Clearing the mask bit makes it eligible again.
- R5: An acknowledge of an eligible request i clears pending bit i and sets in-service bit i. One cycle after the inta edge, vec_valid is 1 for one cycle and vec_out = {base[7:3], i[2:0]}.
- R6: While in-service bit k is set, a pending request with index k or higher does not raise int_out. A request with an index below k does raise it (nesting).
- R7: Writing the control register (address 3) with bit 1 set clears only the lowest-index set in-service bit. If no in-service bit is set, nothing changes.
- R8: An acknowledge with no eligible request leaves both sets unchanged and returns vec_out = {base[7:3], 3'b111} with vec_valid 1.
- R9: In the master role, cas_out carries the index of the eligible winner. cas_sel_out is 1 when the cascade word bit for that index is 1. Acknowledging such a request updates the in-service set but leaves vec_valid at 0.
- R10: In the slave role (control bit 0 = 1), an acknowledge is honoured only when cas_sel_in is 1 and cas_in equals cascade word bits [2:0]. Otherwise it produces no vector and changes no state.
- R11: int_out is a registered output. It is 1 exactly when, in the previous cycle, some request was pending, unmasked and not blocked by the in-service set.
- R12: The register map, with cfg_rdata valid one cycle after cfg_addr, is:
  - address 0: type base (bits 7:3 stored, bits 2:0 read 0)
  - address 1: mask
  - address 2: cascade word
  - address 3: control (bit 0 is the role; reads return the role)
  - address 4: pending set (read only)
  - address 5: in-service set (read only)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request lines, rising edge sets pending |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Registered read data |
| inta | input | 1 | Acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Interrupt type number |
| vec_valid | output | 1 | vec_out is valid this cycle |
| cas_out | output | 3 | Master: identifier of the winning input |
| cas_sel_out | output | 1 | Master: winning input hosts a slave |
| cas_in | input | 3 | Slave: identifier broadcast by the master |
| cas_sel_in | input | 1 | Slave: the broadcast identifier is valid |

## Verification
Every cycle, the assertions check four things. Pending bits disappear only through an acknowledge. An acknowledged index lands in the in-service set. An end-of-interrupt retires exactly one entry and never adds one. int_out never rises without an unmasked pending request. The assertions also check the spurious-acknowledge vector and that a slave stays silent without a selected identifier. Fixed priority order, blocking and nesting under the in-service set, and the exact type numbers for a given base can only be shown by the bench's scenarios. The same holds for masked requests persisting, and for the cascade identifier matching across master and slave roles. The bench compares these against its own model of the pending, mask and in-service sets.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int CFG_ADDR_W = 3;

  typedef enum logic [CFG_ADDR_W-1:0] {
    SEL_BASE  = 3'd0,
    SEL_MASK  = 3'd1,
    SEL_CASC  = 3'd2,
    SEL_CTRL  = 3'd3,
    SEL_PEND  = 3'd4,
    SEL_SERV  = 3'd5
  } reg_sel_e;

  localparam int CTRL_ROLE_BIT = 0;
  localparam int CTRL_EOI_BIT  = 1;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);

  // Lowest set index wins: scan from the top so the last hit is the lowest.
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any = |vec;

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_in,
  input  logic          clr_valid,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  pend
);

  logic [N-1:0] line_q;
  logic [N-1:0] rise;
  logic [N-1:0] clr_mask;

  assign rise = irq_in & ~line_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_clr
      assign clr_mask[g] = clr_valid && (clr_idx == IW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      pend   <= '0;
    end else begin
      line_q <= irq_in;
      pend   <= (pend & ~clr_mask) | rise;
    end
  end

  // R2: without an acknowledge no pending bit may drop
  p_pend_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !clr_valid |=> ((pend & $past(pend)) == $past(pend)));

endmodule

// File: rtl/irq_inservice.sv
module irq_inservice #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_valid,
  input  logic [IW-1:0] set_idx,
  input  logic          eoi,
  output logic [N-1:0]  serv
);

  logic [N-1:0] set_mask;
  logic [N-1:0] lowest;

  // Isolate the lowest set bit (most urgent entry in service).
  assign lowest = serv & (~serv + N'(1));

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_set
      assign set_mask[g] = set_valid && (set_idx == IW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      serv <= '0;
    end else begin
      serv <= (serv & ~(eoi ? lowest : '0)) | set_mask;
    end
  end

  // R5: an accepted acknowledge lands in the in-service set
  p_serv_set_r5: assert property (@(posedge clk) disable iff (rst)
    set_valid |=> serv[$past(set_idx)]);

  // R7: end-of-interrupt retires exactly one entry and adds none
  p_eoi_one_r7: assert property (@(posedge clk) disable iff (rst)
    (eoi && !set_valid && (serv != '0)) |=>
      (($countones(serv) == $countones($past(serv)) - 1) &&
       ((serv & ~$past(serv)) == '0)));

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  serv,
  output logic          eligible,
  output logic [IW-1:0] win_idx
);

  logic [N-1:0]  live;
  logic          live_any;
  logic          serv_any;
  logic [IW-1:0] serv_idx;

  assign live = pend & ~mask;

  irq_prio_enc #(.W(N), .IW(IW)) u_live_enc (
    .vec (live),
    .any (live_any),
    .idx (win_idx)
  );

  irq_prio_enc #(.W(N), .IW(IW)) u_serv_enc (
    .vec (serv),
    .any (serv_any),
    .idx (serv_idx)
  );

  // A winner passes only if it outranks every entry already in service.
  assign eligible = live_any && (!serv_any || (win_idx < serv_idx));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int N_IRQ  = 8,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_IRQ-1:0]      irq_in,
  input  logic                  cfg_we,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0]     cfg_wdata,
  output logic [DATA_W-1:0]     cfg_rdata,
  input  logic                  inta,
  output logic                  int_out,
  output logic [DATA_W-1:0]     vec_out,
  output logic                  vec_valid,
  output logic [$clog2(N_IRQ)-1:0] cas_out,
  output logic                  cas_sel_out,
  input  logic [$clog2(N_IRQ)-1:0] cas_in,
  input  logic                  cas_sel_in
);

  localparam int IDX_W  = $clog2(N_IRQ);
  localparam int BASE_W = DATA_W - IDX_W;

  logic [BASE_W-1:0] base_r;
  logic [N_IRQ-1:0]  mask_r;
  logic [DATA_W-1:0] casc_r;
  logic              role_slave;

  logic [N_IRQ-1:0]  pend;
  logic [N_IRQ-1:0]  serv;
  logic              eligible;
  logic [IDX_W-1:0]  win_idx;

  logic              wr_ctrl;
  logic              eoi_cmd;
  logic              ack_hit;
  logic              take;
  logic              routed;
  logic [N_IRQ-1:0]  slave_map;
  logic [IDX_W-1:0]  own_id;

  assign slave_map = casc_r[N_IRQ-1:0];
  assign own_id    = casc_r[IDX_W-1:0];
  assign wr_ctrl   = cfg_we && (reg_sel_e'(cfg_addr) == SEL_CTRL);
  assign eoi_cmd   = wr_ctrl && cfg_wdata[CTRL_EOI_BIT];

  // The acknowledge is addressed to this controller unless it is a slave
  // whose identifier was not selected by the master.
  assign ack_hit = inta && (!role_slave || (cas_sel_in && (cas_in == own_id)));
  assign take    = ack_hit && eligible;
  assign routed  = !role_slave && slave_map[win_idx];

  irq_req_latch #(.N(N_IRQ), .IW(IDX_W)) u_req (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .clr_valid (take),
    .clr_idx   (win_idx),
    .pend      (pend)
  );

  irq_resolver #(.N(N_IRQ), .IW(IDX_W)) u_res (
    .pend     (pend),
    .mask     (mask_r),
    .serv     (serv),
    .eligible (eligible),
    .win_idx  (win_idx)
  );

  irq_inservice #(.N(N_IRQ), .IW(IDX_W)) u_serv (
    .clk       (clk),
    .rst       (rst),
    .set_valid (take),
    .set_idx   (win_idx),
    .eoi       (eoi_cmd),
    .serv      (serv)
  );

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      base_r     <= '0;
      mask_r     <= '0;
      casc_r     <= '0;
      role_slave <= 1'b0;
    end else if (cfg_we) begin
      case (reg_sel_e'(cfg_addr))
        SEL_BASE: base_r     <= cfg_wdata[DATA_W-1:IDX_W];
        SEL_MASK: mask_r     <= cfg_wdata[N_IRQ-1:0];
        SEL_CASC: casc_r     <= cfg_wdata;
        SEL_CTRL: role_slave <= cfg_wdata[CTRL_ROLE_BIT];
        default:  ;
      endcase
    end
  end

  // Registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      case (reg_sel_e'(cfg_addr))
        SEL_BASE: cfg_rdata <= {base_r, {IDX_W{1'b0}}};
        SEL_MASK: cfg_rdata <= DATA_W'(mask_r);
        SEL_CASC: cfg_rdata <= casc_r;
        SEL_CTRL: cfg_rdata <= DATA_W'(role_slave);
        SEL_PEND: cfg_rdata <= DATA_W'(pend);
        SEL_SERV: cfg_rdata <= DATA_W'(serv);
        default:  cfg_rdata <= '0;
      endcase
    end
  end

  // Processor-facing and cascade outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      int_out     <= 1'b0;
      vec_out     <= '0;
      vec_valid   <= 1'b0;
      cas_out     <= '0;
      cas_sel_out <= 1'b0;
    end else begin
      int_out     <= eligible;
      vec_valid   <= ack_hit && !(take && routed);
      vec_out     <= {base_r, (take ? win_idx : {IDX_W{1'b1}})};
      cas_out     <= (!role_slave && eligible) ? win_idx : '0;
      cas_sel_out <= !role_slave && eligible && slave_map[win_idx];
    end
  end

  // R5: a vector only ever follows an acknowledge
  p_vec_after_ack_r5: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(inta));

  // R4: the interrupt line needs an unmasked pending request behind it
  p_int_cause_r4: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past((pend & ~mask_r) != '0));

  // R8: an acknowledge with nothing eligible yields the all-ones index
  p_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    (inta && !role_slave && !eligible) |=>
      (vec_valid && (vec_out[IDX_W-1:0] == {IDX_W{1'b1}})));

  // R10: an unselected slave stays silent and keeps its in-service set
  p_slave_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (role_slave && inta && !cas_sel_in && !eoi_cmd) |=>
      (!vec_valid && $stable(serv)));

endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] irq_in;
  logic       cfg_we;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       inta;
  logic       int_out;
  logic [7:0] vec_out;
  logic       vec_valid;
  logic [2:0] cas_out;
  logic       cas_sel_out;
  logic [2:0] cas_in;
  logic       cas_sel_in;

  always #10 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .inta(inta), .int_out(int_out),
    .vec_out(vec_out), .vec_valid(vec_valid), .cas_out(cas_out),
    .cas_sel_out(cas_sel_out), .cas_in(cas_in), .cas_sel_in(cas_sel_in)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_pend, m_serv, m_mask, m_base;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int low_idx(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic model_elig(input logic [7:0] p, input logic [7:0] m, input logic [7:0] s);
    int a = low_idx(p & ~m);
    return (a < 8) && (a < low_idx(s));
  endfunction

  function automatic logic [7:0] model_vec(input logic [7:0] b, input int idx);
    return {b[7:3], idx[2:0]};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); d = cfg_rdata;
  endtask

  task automatic pulse(input logic [7:0] bits);
    @(negedge clk); irq_in = bits;
    @(negedge clk); irq_in = 8'h00;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic do_ack(output logic [7:0] v, output logic vv);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0; v = vec_out; vv = vec_valid;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] v;
    logic       vv;
    void'($urandom(32'd1234));
    rst = 1'b1; irq_in = '0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    inta = 0; cas_in = '0; cas_sel_in = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 int_out", int_out, 0);
    chk("R1 vec_valid", vec_valid, 0);
    chk("R1 cas_sel_out", cas_sel_out, 0);
    rd(3'd4, d); chk("R1 pending", d, 0);
    rd(3'd5, d); chk("R1 in-service", d, 0);
    rd(3'd1, d); chk("R1 mask", d, 0);
    rd(3'd0, d); chk("R1 base", d, 0);

    // R12 register map readback
    wr(3'd0, 8'h47); rd(3'd0, d); chk("R12 base low bits", d, 8'h40);
    wr(3'd2, 8'h5a); rd(3'd2, d); chk("R12 cascade word", d, 8'h5a);
    wr(3'd2, 8'h00);

    // R2 / R11: two requests pend and raise the line
    pulse(8'h24);
    rd(3'd4, d); chk("R2 pending set", d, 8'h24);
    chk("R11 int raised", int_out, 1);

    // R3 / R5: lowest index wins, moves to in-service
    do_ack(v, vv);
    chk("R5 vec valid", vv, 1);
    chk("R3 vec index 2", v, 8'h42);
    rd(3'd4, d); chk("R5 pending cleared", d, 8'h20);
    rd(3'd5, d); chk("R5 in-service set", d, 8'h04);
    chk("R6 lower priority blocked", int_out, 0);

    // R6 nesting: a more urgent request still gets through
    pulse(8'h02);
    chk("R6 nested int", int_out, 1);
    do_ack(v, vv); chk("R6 nested vec", v, 8'h41);
    rd(3'd5, d); chk("R6 two in service", d, 8'h06);

    // R7: EOI retires only the most urgent entry
    wr(3'd3, 8'h02);
    rd(3'd5, d); chk("R7 lowest cleared", d, 8'h04);
    chk("R7 still blocked", int_out, 0);
    wr(3'd3, 8'h02);
    rd(3'd5, d); chk("R7 empty", d, 8'h00);
    chk("R7 unblocked", int_out, 1);
    do_ack(v, vv); chk("R3 vec index 5", v, 8'h45);
    wr(3'd3, 8'h02);
    wr(3'd3, 8'h02);
    rd(3'd5, d); chk("R7 eoi on empty", d, 8'h00);

    // R4: masked request stays pending
    wr(3'd1, 8'h08);
    pulse(8'h08);
    chk("R4 masked no int", int_out, 0);
    rd(3'd4, d); chk("R4 masked pending", d, 8'h08);
    wr(3'd1, 8'h00);
    chk("R4 unmasked int", int_out, 1);
    do_ack(v, vv); chk("R4 vec after unmask", v, 8'h43);
    wr(3'd3, 8'h02);

    // R8: spurious acknowledge
    do_ack(v, vv);
    chk("R8 spurious valid", vv, 1);
    chk("R8 spurious vec", v, 8'h47);
    rd(3'd5, d); chk("R8 in-service unchanged", d, 8'h00);

    // R2: a held level does not retrigger
    @(negedge clk); irq_in = 8'h01;
    repeat (3) @(negedge clk);
    do_ack(v, vv); chk("R2 held vec", v, 8'h40);
    wr(3'd3, 8'h02);
    chk("R2 held no retrigger", int_out, 0);
    rd(3'd4, d); chk("R2 held pending clear", d, 8'h00);
    @(negedge clk); irq_in = 8'h00;
    @(negedge clk);

    // R9: master routes input 4 to a slave
    wr(3'd2, 8'h10);
    pulse(8'h10);
    chk("R9 cas_sel_out", cas_sel_out, 1);
    chk("R9 cas_out", cas_out, 4);
    do_ack(v, vv); chk("R9 no master vector", vv, 0);
    rd(3'd5, d); chk("R9 master in-service", d, 8'h10);
    wr(3'd3, 8'h02);
    wr(3'd2, 8'h00);

    // R10: slave role, identifier 3
    wr(3'd2, 8'h03);
    wr(3'd3, 8'h01);
    rd(3'd3, d); chk("R12 role readback", d, 8'h01);
    pulse(8'h01);
    chk("R10 slave int", int_out, 1);
    @(negedge clk); cas_sel_in = 1; cas_in = 3'd2;
    do_ack(v, vv); chk("R10 wrong id silent", vv, 0);
    rd(3'd5, d); chk("R10 wrong id no state", d, 8'h00);
    cas_in = 3'd3;
    do_ack(v, vv); chk("R10 match vec valid", vv, 1);
    chk("R10 match vec", v, 8'h40);
    rd(3'd5, d); chk("R10 match in-service", d, 8'h01);
    cas_sel_in = 0;
    wr(3'd3, 8'h03);
    wr(3'd3, 8'h00);
    wr(3'd2, 8'h00);

    // Random phase against the bench model
    m_base = ($urandom % 32) << 3;
    wr(3'd0, m_base);
    m_mask = 0; m_pend = 0; m_serv = 0;
    wr(3'd1, 8'h00);
    for (int it = 0; it < 80; it++) begin
      int op = $urandom % 4;
      case (op)
        0: begin
          logic [7:0] b = 8'($urandom);
          pulse(b); m_pend |= b;
        end
        1: begin
          logic [7:0] mk = 8'($urandom) & 8'($urandom);
          wr(3'd1, mk); m_mask = mk;
        end
        2: begin
          logic [7:0] ev;
          if (model_elig(m_pend, m_mask, m_serv)) begin
            int w = low_idx(m_pend & ~m_mask);
            ev = model_vec(m_base, w);
            m_pend[w] = 1'b0; m_serv[w] = 1'b1;
          end else begin
            ev = model_vec(m_base, 7);
          end
          do_ack(v, vv);
          chk("R3 random vec", v, ev);
          chk("R5 random valid", vv, 1);
        end
        default: begin
          int s = low_idx(m_serv);
          if (s < 8) m_serv[s] = 1'b0;
          wr(3'd3, 8'h02);
        end
      endcase
      chk("R11 random int", int_out, model_elig(m_pend, m_mask, m_serv));
      rd(3'd4, d); chk("R2 random pending", d, m_pend);
      rd(3'd5, d); chk("R7 random in-service", d, m_serv);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule